// File: doc/BRIEF.md
# Direct-Address Byte Load Sequencer

This block carries out the two-word "load byte from a direct data address" instruction of a small 8-bit microcontroller core. When `start` is raised with the first instruction word and that word's own program address, the sequencer checks the opcode. It then reads the address word that follows from program memory. It places an 8-bit page value above that 16-bit address and reads one byte through a request/ready data port. The byte is written into the 32-entry register file and the program counter moves past both words.

The number of cycles depends on the timing mode and on the region of the 16-bit address: the I/O register window, internal SRAM, or the slow non-volatile window. The non-volatile window costs one extra cycle, plus any cycles in which the memory holds `rd_ready` low. A first word that is not this instruction raises a one-cycle `illegal` flag and causes no access. The block has no status flags, so it cannot change any.

Top module: `lds_sequencer`

## Requirements
- R1: A first word is accepted only when `(instr & 16'hFE0F) == 16'h9000`. The destination register index is `instr[8:4]` and is driven on `rf_waddr` during the write.
- R2: In the cycle after acceptance, `pm_addr` equals `pc_in + 1`, and the `pm_data` read in that cycle is the 16-bit data address k.
- R3: `rd_addr` equals `{page, k}`, with `page` sampled at acceptance. While `rd_req` is high and `rd_ready` is low, `rd_req` stays high and `rd_addr` holds still.
- R4: In the cycle where `rd_req` and `rd_ready` are both high, `done` and `rf_we` pulse for exactly that one cycle, and `rf_wdata` equals `rd_data`.
- R5: After `done`, `pc_out` equals `pc_in + 2` modulo 2^16. At all other times `pc_out` holds its value.
- R6: With `ext_timing` = 0, the cycle count is 2 for any k below 16'h8000. The count runs from the edge that accepts `start` up to and including the `done` cycle.
- R7: With `ext_timing` = 1, the cycle count is 3 for k from 16'h0060 to 16'h7FFF, and 2 for k from 16'h0000 to 16'h005F.
- R8: For k at 16'h8000 or above, the count is the mode's SRAM count plus one, plus every cycle in which `rd_ready` is low.
- R9: A `start` that arrives while `busy` is high is ignored. The running instruction finishes with its own register, address and program counter, and no second run follows.
- R10: A mismatching first word gives `illegal` = 1 in the next cycle only, with no `rd_req`, no `rf_we`, `busy` low and `pc_out` unchanged.
- R11: After reset, `busy`, `done`, `rd_req`, `rf_we` and `illegal` are 0 and `pc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Present a first instruction word |
| instr | input | 16 | First instruction word |
| pc_in | input | 16 | Program address of the first word |
| page | input | 8 | Page bits placed above the 16-bit address |
| ext_timing | input | 1 | 0: two-cycle base, 1: three-cycle base with I/O shortcut |
| pm_addr | output | 16 | Program memory word address |
| pm_data | input | 16 | Program memory word (combinational read) |
| rd_req | output | 1 | Data read request |
| rd_addr | output | 24 | Data read address |
| rd_data | input | 8 | Read byte |
| rd_ready | input | 1 | Read byte valid this cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 8 | Register file write byte |
| pc_out | output | 16 | Updated program counter |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle pulse for a mismatching first word |

## Verification
The vector table runs the load across all three address regions in both timing modes. Some vectors sit on either side of the I/O window's last address and the non-volatile start, which separates a wrong region comparison from a wrong pad count. The table uses destinations r0 and r31 and nonzero pages, so that a dropped page or swapped index field shows up as a wrong address or index. Its varying wait counts show whether the sequencer stalls for exactly as long as the memory does. A program counter at 16'hFFFE checks the wrap. Directed tests cover several near-miss opcodes and a second `start` sent mid-instruction.

// File: rtl/lds_pkg.sv
package lds_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_PAD, ST_ACCESS} lds_state_e;

  localparam logic [15:0] LDS_MASK = 16'hFE0F;
  localparam logic [15:0] LDS_CODE = 16'h9000;

  function automatic logic is_lds(input logic [15:0] w);
    return (w & LDS_MASK) == LDS_CODE;
  endfunction

  function automatic logic [4:0] dest_of(input logic [15:0] w);
    return w[8:4];
  endfunction

  // extra cycles between address fetch and data request
  function automatic logic [1:0] pad_cycles(input logic ext, input logic io, input logic nvm);
    return {1'b0, ext & ~io} + {1'b0, nvm};
  endfunction
endpackage

// File: rtl/lds_decoder.sv
module lds_decoder
  import lds_pkg::*;
(
  input  logic [15:0] word,
  output logic        match,
  output logic [4:0]  dest
);
  always_comb begin
    match = is_lds(word);
    dest  = dest_of(word);
  end
endmodule

// File: rtl/lds_region_map.sv
module lds_region_map
  import lds_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IO_LAST  = 16'h005F,
  parameter logic [15:0] NVM_BASE = 16'h8000
) (
  input  logic [ADDR_W-1:0] k,
  input  logic              ext,
  output logic              in_io,
  output logic              in_nvm,
  output logic [1:0]        pads
);
  localparam logic [ADDR_W-1:0] IO_TOP  = ADDR_W'(IO_LAST);
  localparam logic [ADDR_W-1:0] NVM_LOW = ADDR_W'(NVM_BASE);

  always_comb begin
    in_io  = (k <= IO_TOP);
    in_nvm = (k >= NVM_LOW);
    pads   = pad_cycles(ext, in_io, in_nvm);
  end
endmodule

// File: rtl/lds_ctrl.sv
module lds_ctrl
  import lds_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter int DEST_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     match,
  input  logic [DEST_W-1:0]        dest,
  input  logic [PC_W-1:0]          pc_in,
  input  logic [PAGE_W-1:0]        page,
  input  logic                     ext_timing,
  input  logic [ADDR_W-1:0]        pm_data,
  input  logic [1:0]               pads,
  input  logic                     rd_ready,
  output logic                     ext_q,
  output logic [PC_W-1:0]          pm_addr,
  output logic                     rd_req,
  output logic [PAGE_W+ADDR_W-1:0] rd_addr,
  output logic [DEST_W-1:0]        dest_q,
  output logic [PC_W-1:0]          pc_out,
  output logic                     busy,
  output logic                     done,
  output logic                     illegal,
  output logic                     accept_evt,
  output logic                     fetch_evt
);
  lds_state_e        state;
  logic [PC_W-1:0]   pc_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] k_q;
  logic [1:0]        pad_q;

  always_comb begin
    accept_evt = (state == ST_IDLE) && start && match;
    fetch_evt  = (state == ST_FETCH);
    rd_req     = (state == ST_ACCESS);
    done       = rd_req && rd_ready;
    busy       = (state != ST_IDLE);
    pm_addr    = pc_q + PC_W'(1);
    rd_addr    = {page_q, k_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pc_q    <= '0;
      page_q  <= '0;
      k_q     <= '0;
      pad_q   <= '0;
      dest_q  <= '0;
      ext_q   <= 1'b0;
      pc_out  <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= (state == ST_IDLE) && start && !match;
      unique case (state)
        ST_IDLE: begin
          if (accept_evt) begin
            pc_q   <= pc_in;
            page_q <= page;
            dest_q <= dest;
            ext_q  <= ext_timing;
            state  <= ST_FETCH;
          end
        end
        ST_FETCH: begin
          k_q   <= pm_data;
          pad_q <= pads;
          state <= (pads == 2'd0) ? ST_ACCESS : ST_PAD;
        end
        ST_PAD: begin
          if (pad_q == 2'd1) state <= ST_ACCESS;
          else               pad_q <= pad_q - 2'd1;
        end
        ST_ACCESS: begin
          if (rd_ready) begin
            pc_out <= pc_q + PC_W'(2);
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lds_sequencer.sv
module lds_sequencer #(
  parameter int          PC_W     = 16,
  parameter int          ADDR_W   = 16,
  parameter int          PAGE_W   = 8,
  parameter int          DATA_W   = 8,
  parameter int          RF_AW    = 5,
  parameter logic [15:0] IO_LAST  = 16'h005F,
  parameter logic [15:0] NVM_BASE = 16'h8000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [15:0]              instr,
  input  logic [PC_W-1:0]          pc_in,
  input  logic [PAGE_W-1:0]        page,
  input  logic                     ext_timing,
  output logic [PC_W-1:0]          pm_addr,
  input  logic [ADDR_W-1:0]        pm_data,
  output logic                     rd_req,
  output logic [PAGE_W+ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0]        rd_data,
  input  logic                     rd_ready,
  output logic                     rf_we,
  output logic [RF_AW-1:0]         rf_waddr,
  output logic [DATA_W-1:0]        rf_wdata,
  output logic [PC_W-1:0]          pc_out,
  output logic                     busy,
  output logic                     done,
  output logic                     illegal
);
  logic       match;
  logic [4:0] dest_raw;
  logic       in_io, in_nvm, ext_q;
  logic [1:0] pads;
  logic       accept_evt, fetch_evt;

  lds_decoder u_dec (.word(instr), .match(match), .dest(dest_raw));

  lds_region_map #(.ADDR_W(ADDR_W), .IO_LAST(IO_LAST), .NVM_BASE(NVM_BASE)) u_region (
    .k(pm_data), .ext(ext_q), .in_io(in_io), .in_nvm(in_nvm), .pads(pads)
  );

  lds_ctrl #(.PC_W(PC_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DEST_W(RF_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .match(match),
    .dest(RF_AW'(dest_raw)), .pc_in(pc_in), .page(page), .ext_timing(ext_timing),
    .pm_data(pm_data), .pads(pads), .rd_ready(rd_ready), .ext_q(ext_q),
    .pm_addr(pm_addr), .rd_req(rd_req), .rd_addr(rd_addr), .dest_q(rf_waddr),
    .pc_out(pc_out), .busy(busy), .done(done), .illegal(illegal),
    .accept_evt(accept_evt), .fetch_evt(fetch_evt)
  );

  always_comb begin
    rf_we    = done;
    rf_wdata = rd_data;
  end
endmodule

// File: rtl/lds_sequencer_chk.sv
module lds_sequencer_chk #(
  parameter int PC_W = 16,
  parameter int AW   = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            rd_req,
  input logic [AW-1:0]   rd_addr,
  input logic            rd_ready,
  input logic            rf_we,
  input logic            done,
  input logic            busy,
  input logic            illegal,
  input logic [PC_W-1:0] pc_out,
  input logic            accept_evt,
  input logic            fetch_evt
);
  // R2
  accept_then_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> fetch_evt);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R4
  done_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rf_we && rd_req && rd_ready));
  // R5
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(pc_out));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |-> !accept_evt);
  // R10
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!busy && !rd_req && !rf_we));
endmodule

bind lds_sequencer lds_sequencer_chk #(.PC_W(PC_W), .AW(PAGE_W + ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .rf_we(rf_we), .done(done), .busy(busy), .illegal(illegal),
  .pc_out(pc_out), .accept_evt(accept_evt), .fetch_evt(fetch_evt)
);

// File: tb/test_lds_sequencer.sv
`timescale 1ns/1ps
module test_lds_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_in = '0;
  logic [7:0]  page = '0;
  logic        ext_timing = 1'b0;
  logic [15:0] pm_addr, pm_data;
  logic        rd_req, rd_ready, rf_we, busy, done, illegal;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data, rf_wdata;
  logic [4:0]  rf_waddr;
  logic [15:0] pc_out;

  int errors = 0;
  int checks = 0;
  int wcnt = 0;
  int cur_waits = 0;
  logic [15:0] cur_k = '0;
  logic [15:0] cur_pc = '0;

  always #2.5 clk = ~clk;

  lds_sequencer i_lds_sequencer (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
    .page(page), .ext_timing(ext_timing), .pm_addr(pm_addr), .pm_data(pm_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data), .rd_ready(rd_ready),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_out(pc_out),
    .busy(busy), .done(done), .illegal(illegal)
  );

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  // behavioural memories
  assign pm_data  = (pm_addr == cur_pc + 16'd1) ? cur_k : 16'hDEAD;
  assign rd_data  = mem_byte(rd_addr);
  assign rd_ready = rd_req && (wcnt >= ((rd_addr[15:0] >= 16'h8000) ? cur_waits : 0));

  always @(posedge clk) begin
    if (!rst_n) wcnt <= 0;
    else if (rd_req && !rd_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
  end

  task automatic check(input logic ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // {instr, k, page, pc, ext, waits}
  localparam int NV = 9;
  localparam logic [60:0] VECS [0:NV-1] = '{
    {16'h9000, 16'h0100, 8'h00, 16'h0010, 1'b0, 4'd0},
    {16'h91F0, 16'h0020, 8'h00, 16'h0200, 1'b1, 4'd0},
    {16'h9150, 16'h0060, 8'h00, 16'h0300, 1'b1, 4'd0},
    {16'h9050, 16'h005F, 8'h00, 16'h0400, 1'b1, 4'd0},
    {16'h9100, 16'h8000, 8'h00, 16'h0500, 1'b0, 4'd0},
    {16'h90A0, 16'hFFFF, 8'h01, 16'h0600, 1'b1, 4'd3},
    {16'h9030, 16'h7FFF, 8'hA5, 16'h0700, 1'b0, 4'd0},
    {16'h91E0, 16'h1234, 8'hFF, 16'hFFFE, 1'b1, 4'd0},
    {16'h9070, 16'h8001, 8'h3C, 16'h0800, 1'b1, 4'd5}
  };

  task automatic run_load(input logic [15:0] w, input logic [15:0] k, input logic [7:0] pg,
                          input logic [15:0] pc, input logic ext, input int waits);
    int n;
    int exp_lat;
    logic [23:0] ea;
    exp_lat = (ext && k > 16'h005F) ? 3 : 2;
    if (k >= 16'h8000) exp_lat = (ext ? 3 : 2) + 1 + waits;
    ea = {pg, k};
    @(negedge clk);
    instr = w; cur_k = k; page = pg; pc_in = pc; cur_pc = pc; ext_timing = ext; cur_waits = waits;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    if (busy) check(pm_addr == pc + 16'd1, "R2", "pm_addr", pm_addr, pc + 16'd1);
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (k >= 16'h8000) check(n == exp_lat, "R8", "latency", n, exp_lat);
    else if (ext)      check(n == exp_lat, "R7", "latency", n, exp_lat);
    else               check(n == exp_lat, "R6", "latency", n, exp_lat);
    check(rf_we && rf_waddr == w[8:4], "R1", "rf_waddr", rf_waddr, w[8:4]);
    check(rd_addr == ea, "R3", "rd_addr", rd_addr, ea);
    check(rf_wdata == mem_byte(ea), "R4", "rf_wdata", rf_wdata, mem_byte(ea));
    @(negedge clk);
    check(!done && !rf_we && !busy, "R4", "done after pulse", done, 0);
    check(pc_out == pc + 16'd2, "R5", "pc_out", pc_out, pc + 16'd2);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    check(!busy && !done && !rd_req && !rf_we && !illegal, "R11", "reset flags",
          {busy, done, rd_req, rf_we, illegal}, 0);
    check(pc_out == 16'h0, "R11", "reset pc_out", pc_out, 0);

    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      v = VECS[i];
      run_load(v[60:45], v[44:29], v[28:21], v[20:5], v[4], int'(v[3:0]));
    end

    // R10 near-miss opcodes
    begin
      logic [15:0] bad [0:3];
      logic [15:0] held;
      bad[0] = 16'h9001; bad[1] = 16'h9200; bad[2] = 16'h8000; bad[3] = 16'h1000;
      for (int j = 0; j < 4; j++) begin
        held = pc_out;
        @(negedge clk);
        instr = bad[j]; pc_in = 16'h4444; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(illegal && !busy && !rd_req, "R10", "illegal pulse", {illegal, busy, rd_req}, 3'b100);
        @(negedge clk);
        check(!illegal && !busy && !rd_req && !rf_we, "R10", "quiet after", {illegal, busy, rd_req}, 0);
        check(pc_out == held, "R10", "pc_out held", pc_out, held);
      end
    end

    // R9 start during busy ignored
    begin
      int n;
      @(negedge clk);
      instr = 16'h9120; cur_k = 16'h9000; page = 8'h02; pc_in = 16'h1000; cur_pc = 16'h1000;
      ext_timing = 1'b0; cur_waits = 4; start = 1'b1;
      @(negedge clk);
      start = 1'b1; instr = 16'h9010; pc_in = 16'h2000;
      @(negedge clk);
      start = 1'b0;
      n = 2;
      while (!done && n < 40) begin
        @(negedge clk);
        n++;
      end
      check(rf_waddr == 5'd18, "R9", "first dest kept", rf_waddr, 18);
      check(rd_addr == 24'h029000, "R9", "first address kept", rd_addr, 24'h029000);
      check(n == 7, "R8", "nvm latency 4 waits", n, 7);
      @(negedge clk);
      check(pc_out == 16'h1002, "R9", "first pc kept", pc_out, 16'h1002);
      @(negedge clk);
      check(!busy && !rd_req, "R9", "no second run", busy, 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule